// File: doc/BRIEF.md
# Primitive-Stepped I2C Bus Master

This block is an I2C bus master that never runs a whole transfer by itself. Software sends it one bus primitive at a time by writing a 3-bit trigger code. The primitives are a start condition, a stop condition, an 8-bit transmit, an 8-bit receive, sending ACK, sending NAK, and sampling the ACK level that a slave returns. Once a primitive has finished, a 3-bit status code reports which one ran and, for the sampling primitive, which level was seen.

SCL and SDA are open-drain. Each line has an enable output: 1 pulls the line low and 0 releases it. The bus level of SDA comes back on an input. Bit timing comes from an internal prescaler that ticks every `PRESCALE` clocks. The low phase and the high phase of SCL each last a programmable number of ticks.

All control goes through a plain 8-bit register bus with single-cycle strobes. There is no stream handshake: `reg_rdata` is combinational from `reg_addr`, and a write takes effect at the clock edge where `reg_wr` is high. A completion flag and an overrun flag, each with its own enable, drive one level-sensitive interrupt.

Register map:

| Address | Name | Access | Content |
|---|---|---|---|
| 0 | trigger | write / read back | trigger code |
| 1 | transmit data | read / write | byte to send |
| 2 | receive data | read | last received byte; reading it marks the byte as read |
| 3 | enables | read / write | bit0 completion enable, bit1 overrun enable |
| 4 | flags | read; write 1 to clear | see R2, R10 and R11 |
| 5 | low ticks | read / write | SCL low phase length in prescaler ticks (0 counts as 1) |
| 6 | high ticks | read / write | SCL high phase length in prescaler ticks (0 counts as 1) |

Top module: `i2c_prim_master`

## Requirements
- R1: After reset the busy bit, the status code, both flags, both enables and `irq` read 0, and both line enables are 0 (released).
- R2: Writing a code from 0 to 6 to address 0 while idle starts one primitive. The codes are 0 start, 1 stop, 2 transmit, 3 receive, 4 send ACK, 5 send NAK, 6 sample ACK. The busy bit (bit 5 of address 4) reads 1 from the next cycle until the primitive ends. Code 7 is ignored: busy stays 0 and the flags do not change.
- R3: A trigger write made while busy is 1 is ignored. The running primitive completes and reports its own status.
- R4: A start primitive pulls SDA low while SCL is released (SDA falls while SCL is high). It ends with both lines held low and status 0 (bits 4:2 of address 4).
- R5: A stop primitive releases SDA while SCL is released. It ends with both lines released and status 1.
- R6: Transmit drives the byte from address 1 on 8 SCL pulses, most significant bit first, and then reports status 2.
- R7: Receive samples SDA at the end of each of 8 SCL high phases, most significant bit first. It places the byte at address 2 and reports status 3.
- R8: Send ACK holds SDA low for one SCL pulse. Send NAK leaves SDA released for one pulse. Both report status 4.
- R9: Sample ACK releases SDA for one SCL pulse and reports status 5 if SDA was low and status 6 if SDA was high. Status 7 never occurs.
- R10: When any primitive ends, the completion flag (bit 0 of address 4) becomes 1. Writing 1 to bit 0 clears it. `irq` is 1 while the flag and its enable (bit 0 of address 3) are both 1.
- R11: If a receive ends while the previous byte at address 2 is still unread, the overrun flag (bit 1 of address 4) becomes 1 and the new byte replaces the old one. Writing 1 to bit 1 clears the flag. The flag drives `irq` only when bit 1 of address 3 is 1.
- R12: Bits 7:2 of address 3 and bits 7:6 of address 4 always read 0. Outside start and stop, SDA changes only while SCL is low.
- R13: Each SCL high phase lasts high-ticks × `PRESCALE` clocks and each low phase inside a byte lasts low-ticks × `PRESCALE` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (has a side effect only at address 2) |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational from `reg_addr` |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | level sensed on the SDA bus |
| irq | output | 1 | interrupt request, level |

## Verification
A corrupted step or bit counter would show at the lines within one byte time. The captured byte would differ from the transmit register, the SCL pulse count would not be 8, or a phase length measured in clocks would be off. A wrong operation register or status path would show in the status code read right after busy falls. It could also show as an SDA edge while SCL is high outside start or stop, caught on the clock edge where it happens. Flag and enable faults would show on `irq` in the first cycle after completion or after a clearing write.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

  typedef enum logic [2:0] {
    TRG_START  = 3'd0,
    TRG_STOP   = 3'd1,
    TRG_TX     = 3'd2,
    TRG_RX     = 3'd3,
    TRG_ACK    = 3'd4,
    TRG_NAK    = 3'd5,
    TRG_ACKCHK = 3'd6,
    TRG_RSVD   = 3'd7
  } trig_e;

  localparam logic [2:0] ST_START = 3'd0;
  localparam logic [2:0] ST_STOP  = 3'd1;
  localparam logic [2:0] ST_TX    = 3'd2;
  localparam logic [2:0] ST_RX    = 3'd3;
  localparam logic [2:0] ST_SENT  = 3'd4;
  localparam logic [2:0] ST_ACK   = 3'd5;
  localparam logic [2:0] ST_NAK   = 3'd6;

  localparam logic [2:0] A_TRIG = 3'd0;
  localparam logic [2:0] A_TX   = 3'd1;
  localparam logic [2:0] A_RX   = 3'd2;
  localparam logic [2:0] A_IEN  = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
  localparam logic [2:0] A_LO   = 3'd5;
  localparam logic [2:0] A_HI   = 3'd6;

endpackage

// File: rtl/i2c_prim_tick.sv
module i2c_prim_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run_i)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/i2c_prim_seq.sv
module i2c_prim_seq
  import i2c_prim_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  trig_e             code_i,
  input  logic [7:0]        tx_i,
  input  logic [TICK_W-1:0] lo_ticks_i,
  input  logic [TICK_W-1:0] hi_ticks_i,
  input  logic              tick_i,
  input  logic              sda_in_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic [7:0]        rx_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output trig_e             op_o
);
  logic              busy_q;
  trig_e             op_q;
  logic [1:0]        step_q;
  logic [2:0]        bit_q;
  logic [TICK_W-1:0] cnt_q;
  logic [7:0]        shreg_q;
  logic              idle_scl_q, idle_sda_q;
  logic              scl_q, sda_d1_q, sda_q;

  logic              d_scl, d_sda, d_hi, is_bit, dv;
  logic [1:0]        last_step;
  logic [2:0]        last_bit;
  logic [TICK_W-1:0] dur, dur_eff;
  logic              step_end, op_end, sample_now;

  always_comb begin
    is_bit    = (op_q != TRG_START) && (op_q != TRG_STOP);
    last_bit  = ((op_q == TRG_TX) || (op_q == TRG_RX)) ? 3'd7 : 3'd0;
    dv        = (op_q == TRG_TX) ? ~shreg_q[7] : (op_q == TRG_ACK);
    last_step = 2'd1;
    d_scl     = 1'b1;
    d_sda     = dv;
    d_hi      = 1'b0;
    case (op_q)
      TRG_START: begin
        last_step = 2'd3;
        case (step_q)
          2'd0:    begin d_scl = 1'b1; d_sda = 1'b0; d_hi = 1'b0; end
          2'd1:    begin d_scl = 1'b0; d_sda = 1'b0; d_hi = 1'b1; end
          2'd2:    begin d_scl = 1'b0; d_sda = 1'b1; d_hi = 1'b1; end
          default: begin d_scl = 1'b1; d_sda = 1'b1; d_hi = 1'b0; end
        endcase
      end
      TRG_STOP: begin
        last_step = 2'd2;
        case (step_q)
          2'd0:    begin d_scl = 1'b1; d_sda = 1'b1; d_hi = 1'b0; end
          2'd1:    begin d_scl = 1'b0; d_sda = 1'b1; d_hi = 1'b1; end
          default: begin d_scl = 1'b0; d_sda = 1'b0; d_hi = 1'b1; end
        endcase
      end
      default: begin
        d_scl = (step_q == 2'd0);
        d_sda = dv;
        d_hi  = (step_q != 2'd0);
      end
    endcase
  end

  assign dur        = d_hi ? hi_ticks_i : lo_ticks_i;
  assign dur_eff    = (dur == '0) ? TICK_W'(1) : dur;
  assign step_end   = busy_q && tick_i && (cnt_q == dur_eff - 1'b1);
  assign op_end     = step_end && (step_q == last_step) && (bit_q == last_bit);
  assign sample_now = step_end && is_bit && d_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      op_q       <= TRG_START;
      step_q     <= '0;
      bit_q      <= '0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      idle_scl_q <= 1'b0;
      idle_sda_q <= 1'b0;
    end else if (go_i && !busy_q) begin
      busy_q  <= 1'b1;
      op_q    <= code_i;
      step_q  <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
      shreg_q <= tx_i;
    end else if (step_end) begin
      cnt_q <= '0;
      if (sample_now) shreg_q <= {shreg_q[6:0], sda_in_i};
      if (op_end) begin
        busy_q     <= 1'b0;
        idle_scl_q <= (op_q != TRG_STOP);
        idle_sda_q <= (op_q == TRG_START) ? 1'b1 :
                      (op_q == TRG_STOP)  ? 1'b0 : d_sda;
      end else if (step_q == last_step) begin
        step_q <= '0;
        bit_q  <= bit_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Line outputs: SCL follows the step one clock late, SDA two clocks late,
  // so SDA moves after SCL has fallen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b0;
      sda_d1_q <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      scl_q    <= busy_q ? d_scl : idle_scl_q;
      sda_d1_q <= busy_q ? d_sda : idle_sda_q;
      sda_q    <= sda_d1_q;
    end
  end

  always_comb begin
    case (op_q)
      TRG_START:  status_o = ST_START;
      TRG_STOP:   status_o = ST_STOP;
      TRG_TX:     status_o = ST_TX;
      TRG_RX:     status_o = ST_RX;
      TRG_ACKCHK: status_o = sda_in_i ? ST_NAK : ST_ACK;
      default:    status_o = ST_SENT;
    endcase
  end

  assign rx_o     = {shreg_q[6:0], sda_in_i};
  assign busy_o   = busy_q;
  assign done_o   = op_end;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
  assign op_o     = op_q;
endmodule

// File: rtl/i2c_prim_regs.sv
module i2c_prim_regs
  import i2c_prim_pkg::*;
#(
  parameter int TICK_W    = 8,
  parameter int PHASE_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [2:0]        status_i,
  input  logic [7:0]        rx_i,
  input  trig_e             op_i,
  output logic              go_o,
  output trig_e             code_o,
  output logic [7:0]        tx_o,
  output logic [TICK_W-1:0] lo_o,
  output logic [TICK_W-1:0] hi_o,
  output logic              done_flag_o,
  output logic              ovr_flag_o,
  output logic              irq_o
);
  logic [7:0]        tx_q, rx_q;
  logic              unread_q, en_done_q, en_ovr_q, done_f_q, ovr_f_q;
  logic [2:0]        status_q;
  logic [TICK_W-1:0] lo_q, hi_q;
  logic              wr_flag, rd_rx, rx_end;

  assign code_o  = trig_e'(wdata_i[2:0]);
  assign go_o    = wr_i && (addr_i == A_TRIG) && !busy_i && (code_o != TRG_RSVD);
  assign wr_flag = wr_i && (addr_i == A_FLAG);
  assign rd_rx   = rd_i && (addr_i == A_RX);
  assign rx_end  = done_i && (status_i == ST_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '0;
      rx_q      <= '0;
      unread_q  <= 1'b0;
      en_done_q <= 1'b0;
      en_ovr_q  <= 1'b0;
      done_f_q  <= 1'b0;
      ovr_f_q   <= 1'b0;
      status_q  <= ST_START;
      lo_q      <= TICK_W'(PHASE_RST);
      hi_q      <= TICK_W'(PHASE_RST);
    end else begin
      if (wr_i && addr_i == A_TX) tx_q <= wdata_i;
      if (wr_i && addr_i == A_IEN) begin
        en_done_q <= wdata_i[0];
        en_ovr_q  <= wdata_i[1];
      end
      if (wr_i && addr_i == A_LO) lo_q <= wdata_i[TICK_W-1:0];
      if (wr_i && addr_i == A_HI) hi_q <= wdata_i[TICK_W-1:0];

      if (done_i)                     done_f_q <= 1'b1;
      else if (wr_flag && wdata_i[0]) done_f_q <= 1'b0;

      if (rx_end && unread_q && !rd_rx) ovr_f_q <= 1'b1;
      else if (wr_flag && wdata_i[1])   ovr_f_q <= 1'b0;

      if (done_i) status_q <= status_i;

      if (rx_end) begin
        rx_q     <= rx_i;
        unread_q <= 1'b1;
      end else if (rd_rx) begin
        unread_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_TRIG:  rdata_o = {5'b0, op_i};
      A_TX:    rdata_o = tx_q;
      A_RX:    rdata_o = rx_q;
      A_IEN:   rdata_o = {6'b0, en_ovr_q, en_done_q};
      A_FLAG:  rdata_o = {2'b0, busy_i, status_q, ovr_f_q, done_f_q};
      A_LO:    rdata_o = 8'(lo_q);
      A_HI:    rdata_o = 8'(hi_q);
      default: rdata_o = '0;
    endcase
  end

  assign tx_o        = tx_q;
  assign lo_o        = lo_q;
  assign hi_o        = hi_q;
  assign done_flag_o = done_f_q;
  assign ovr_flag_o  = ovr_f_q;
  assign irq_o       = (done_f_q && en_done_q) || (ovr_f_q && en_ovr_q);
endmodule

// File: rtl/i2c_prim_master.sv
module i2c_prim_master
  import i2c_prim_pkg::*;
#(
  parameter int PRESCALE  = 4,
  parameter int TICK_W    = 8,
  parameter int PHASE_RST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in,
  output logic       irq
);
  logic              busy_w, done_w, go_w, tick_w, done_flag_w, ovr_flag_w;
  logic [2:0]        status_w;
  logic [7:0]        rx_w, tx_w;
  logic [TICK_W-1:0] lo_w, hi_w;
  trig_e             code_w, op_w;

  i2c_prim_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_w),
    .tick_o (tick_w)
  );

  i2c_prim_seq #(.TICK_W(TICK_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_w),
    .code_i     (code_w),
    .tx_i       (tx_w),
    .lo_ticks_i (lo_w),
    .hi_ticks_i (hi_w),
    .tick_i     (tick_w),
    .sda_in_i   (sda_in),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .status_o   (status_w),
    .rx_o       (rx_w),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .op_o       (op_w)
  );

  i2c_prim_regs #(.TICK_W(TICK_W), .PHASE_RST(PHASE_RST)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .addr_i      (reg_addr),
    .wdata_i     (reg_wdata),
    .rdata_o     (reg_rdata),
    .busy_i      (busy_w),
    .done_i      (done_w),
    .status_i    (status_w),
    .rx_i        (rx_w),
    .op_i        (op_w),
    .go_o        (go_w),
    .code_o      (code_w),
    .tx_o        (tx_w),
    .lo_o        (lo_w),
    .hi_o        (hi_w),
    .done_flag_o (done_flag_w),
    .ovr_flag_o  (ovr_flag_w),
    .irq_o       (irq)
  );
endmodule

// File: rtl/i2c_prim_chk.sv
module i2c_prim_chk
  import i2c_prim_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       done_flag,
  input logic       ovr_flag,
  input logic       irq,
  input logic [2:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input trig_e      op
);
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status != 3'd7); // R9

  AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && addr == A_TRIG) |=> $stable(op)); // R3

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag || ovr_flag)); // R10

  AST_SDA_STILL_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |->
      (op == TRG_START || op == TRG_STOP)); // R12

  AST_START_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TRG_START && !scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> sda_oe); // R4

  AST_STOP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TRG_STOP && !scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> !sda_oe); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_IEN) |-> (rdata[7:2] == 6'd0)); // R12
endmodule

bind i2c_prim_master i2c_prim_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_w),
  .wr        (reg_wr),
  .addr      (reg_addr),
  .rdata     (reg_rdata),
  .done_flag (done_flag_w),
  .ovr_flag  (ovr_flag_w),
  .irq       (irq),
  .status    (status_w),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .op        (op_w)
);

// File: tb/i2c_prim_master_tb.sv
module i2c_prim_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       slv_pull = 1'b0;
  logic       sda_line;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  assign sda_line = !(sda_oe || slv_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_prim_master #(.PRESCALE(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq));

  // Line monitor, sampled on the falling clock edge
  logic       prev_scl = 1'b0, prev_sda = 1'b0;
  int         hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  int         n_pulse = 0, n_sda_fall_hi = 0, n_sda_rise_hi = 0;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe) begin
        if (!prev_scl) begin last_hi = hi_run; hi_run = 0; end
        lo_run++;
      end else begin
        if (prev_scl) begin
          last_lo = lo_run; lo_run = 0; n_pulse++;
          cap = {cap[6:0], sda_line};
        end
        hi_run++;
        if (!prev_scl && sda_oe != prev_sda) begin
          if (sda_oe) n_sda_fall_hi++; else n_sda_rise_hi++;
        end
      end
      prev_scl = scl_oe;
      prev_sda = sda_oe;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] f;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd4, f);
      if (!f[5]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_op(input logic [2:0] code);
    wr(3'd0, {5'b0, code});
    wait_idle();
  endtask

  function automatic int st(input logic [7:0] f);
    return int'(f[4:2]);
  endfunction

  task automatic t_reset();
    logic [7:0] f, e;
    rd(3'd4, f); rd(3'd3, e);
    chk("R1 flags", f, 0);
    chk("R1 enables", e, 0);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_reserved_code();
    logic [7:0] f;
    wr(3'd0, 8'd7);
    rd(3'd4, f);
    chk("R2 code 7 ignored", f, 0);
  endtask

  task automatic t_start();
    logic [7:0] f;
    int fb = n_sda_fall_hi, rb = n_sda_rise_hi;
    wr(3'd0, 8'd0);
    rd(3'd4, f);
    chk("R2 busy during op", f[5], 1);
    wait_idle();
    rd(3'd4, f);
    chk("R4 start status", st(f), 0);
    chk("R4 start lines", {scl_oe, sda_oe}, 2'b11);
    chk("R4 one SDA fall while SCL high", n_sda_fall_hi - fb, 1);
    chk("R4 no SDA rise while SCL high", n_sda_rise_hi - rb, 0);
    chk("R10 done flag set", f[0], 1);
    chk("R10 no irq while disabled", irq, 0);
    wr(3'd4, 8'h01);
    rd(3'd4, f);
    chk("R10 done flag cleared", f[0], 0);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic [7:0] f;
    int pb = n_pulse, eb = n_sda_fall_hi + n_sda_rise_hi;
    wr(3'd1, b);
    run_op(3'd2);
    rd(3'd4, f);
    chk("R6 tx status", st(f), 2);
    chk("R6 tx pulse count", n_pulse - pb, 8);
    chk("R6 tx byte on SDA", cap, b);
    chk("R12 no SDA change while SCL high", n_sda_fall_hi + n_sda_rise_hi - eb, 0);
  endtask

  task automatic t_ackchk(input bit pull);
    logic [7:0] f;
    slv_pull = pull;
    run_op(3'd6);
    slv_pull = 1'b0;
    rd(3'd4, f);
    chk(pull ? "R9 ACK seen" : "R9 NAK seen", st(f), pull ? 5 : 6);
  endtask

  task automatic rx_op(input logic [7:0] b);
    slv_pull = !b[7];
    wr(3'd0, 8'd3);
    for (int i = 6; i >= 0; i--) begin
      @(negedge scl_oe); @(posedge scl_oe);
      slv_pull = !b[i];
    end
    @(negedge scl_oe); @(posedge scl_oe);
    slv_pull = 1'b0;
    wait_idle();
  endtask

  task automatic t_rx(input logic [7:0] b);
    logic [7:0] f, d;
    rx_op(b);
    rd(3'd4, f);
    chk("R7 rx status", st(f), 3);
    rd(3'd2, d);
    chk("R7 rx byte", d, b);
    chk("R11 no overrun after read", f[1], 0);
  endtask

  task automatic t_overrun();
    logic [7:0] f, d;
    wr(3'd3, 8'h02);
    rx_op(8'h3C);
    rx_op(8'h5A);
    rd(3'd4, f);
    chk("R11 overrun flag", f[1], 1);
    chk("R11 overrun irq", irq, 1);
    rd(3'd2, d);
    chk("R11 new byte kept", d, 8'h5A);
    wr(3'd4, 8'h03);
    rd(3'd4, f);
    chk("R11 overrun cleared", f[1:0], 0);
    chk("R11 irq dropped", irq, 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_send(input bit nak);
    logic [7:0] f;
    int pb = n_pulse;
    run_op(nak ? 3'd5 : 3'd4);
    rd(3'd4, f);
    chk("R8 sent status", st(f), 4);
    chk("R8 one pulse", n_pulse - pb, 1);
    chk(nak ? "R8 NAK level" : "R8 ACK level", cap[0], nak);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] f;
    wr(3'd1, 8'h81);
    wr(3'd0, 8'd2);
    wr(3'd0, 8'd1);
    wait_idle();
    rd(3'd4, f);
    chk("R3 status of running op", st(f), 2);
    chk("R3 stop not executed", scl_oe, 1);
  endtask

  task automatic t_irq_done();
    wr(3'd4, 8'h03);
    wr(3'd3, 8'h01);
    run_op(3'd4);
    chk("R10 irq when enabled", irq, 1);
    wr(3'd4, 8'h01);
    chk("R10 irq after clear", irq, 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_timing();
    wr(3'd5, 8'd1);
    wr(3'd6, 8'd3);
    t_tx(8'h96);
    chk("R13 high phase clocks", last_hi, 3*PRE);
    chk("R13 low phase clocks", last_lo, 1*PRE);
    wr(3'd5, 8'd2);
    wr(3'd6, 8'd2);
  endtask

  task automatic t_stop();
    logic [7:0] f;
    int rb = n_sda_rise_hi;
    run_op(3'd1);
    rd(3'd4, f);
    chk("R5 stop status", st(f), 1);
    chk("R5 lines released", {scl_oe, sda_oe}, 0);
    chk("R5 one SDA rise while SCL high", n_sda_rise_hi - rb, 1);
  endtask

  task automatic t_reserved_bits();
    logic [7:0] e, f;
    wr(3'd3, 8'hFF);
    rd(3'd3, e);
    chk("R12 enable upper bits", e, 8'h03);
    rd(3'd4, f);
    chk("R12 flag upper bits", f[7:6], 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved_code();
    t_start();
    t_tx(8'hC3);
    t_ackchk(1'b1);
    t_ackchk(1'b0);
    t_rx(8'hA5);
    t_overrun();
    t_send(1'b0);
    t_send(1'b1);
    t_busy_ignore();
    t_irq_done();
    t_timing();
    t_stop();
    t_reserved_bits();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule